// File: doc/BRIEF.md
# NMI Trigger Conditioner and Latch

This block takes one external non-maskable interrupt pad and turns it into a clean, active-high level request for a downstream interrupt controller. The pad first passes through a two-flop synchroniser. A detector then watches for one of four trigger conditions: level low, level high, falling edge or rising edge. Every detection sets a sticky latch. The latch output is the request, so the downstream controller always sees an active-high level, whatever the pad polarity or trigger kind.

Software uses a small register port. One register selects the trigger condition. A pending register is cleared by writing a one to its bit 0. An enable register gates what the pending bit reads back. In a level mode the latch keeps being set for as long as the source stays asserted. A clear therefore only takes effect once the source has gone away. Software is expected to wait until the line is quiet before it clears.

Top module: `nmi_trigger_latch`

## Requirements
- R1: While reset is asserted, `irq_req` is 0. Reads at offsets 0x0c, 0x10 and 0x40 all return 0.
- R2: Offset 0x0c holds the trigger mode in bits [1:0] and reads back what was written. The encoding is 0 = level low, 1 = falling edge, 2 = level high, 3 = rising edge.
- R3: In mode 2, a high pad sets the request. A clear issued while the pad is still high leaves the request at 1.
- R4: In mode 0, a low pad sets the request. A clear issued while the pad is still low leaves the request at 1.
- R5: In mode 3, a 0-to-1 pad transition sets the request. A clear then drops it even while the pad stays high. A 1-to-0 transition sets nothing.
- R6: In mode 1, a 1-to-0 pad transition sets the request. A clear then drops it even while the pad stays low. A 0-to-1 transition sets nothing.
- R7: The request holds its value until a clear arrives: a write to offset 0x10 with bit 0 = 1. A clear with no concurrent detection drops the request on the next clock edge.
- R8: A write to offset 0x10 with bit 0 = 0 leaves the request unchanged.
- R9: Offset 0x40 bit 0 is a read/write enable. A read of offset 0x10 returns, in bit 0, the latch output ANDed with that enable bit.
- R10: If a detection and a clear occur in the same cycle, the detection wins and the request is 1 after that edge.
- R11: Writes to other offsets change no register, and reads of other offsets return 0.
- R12: After a pad change, the request cannot change until the third rising clock edge. It is still unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pad | input | 1 | Asynchronous external interrupt pad |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Active-high request to the downstream controller |

## Verification
The assertions check on every cycle that:
- a detection always leaves the request set, even against a clear (R10);
- a lone clear drops the request (R7);
- without a detection or a clear, the request holds (R7);
- an edge mode never detects on two consecutive cycles (R5, R6);
- the pending read is zero whenever the enable is off (R9).

Only the bench scenarios can show the rest:
- the mode-by-mode behaviour at the pad;
- the three-edge latency from the synchroniser;
- a clear being ineffective while a level source stays asserted;
- the handling of writes with bit 0 = 0 and of unmapped offsets.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  // Detection condition for one cycle, given the synchronised sample and the sample one cycle older.
  function automatic logic trig_hit(trig_mode_e m, logic cur, logic prev);
    logic h;
    case (m)
      TRIG_LVL_LO:    h = ~cur;
      TRIG_EDGE_FALL: h = prev & ~cur;
      TRIG_LVL_HI:    h = cur;
      default:        h = cur & ~prev;
    endcase
    return h;
  endfunction

  // Next latch state: a detection dominates a clear.
  function automatic logic latch_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  trig_mode_e mode,
  output logic       hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_in;
  end

  assign hit = trig_hit(mode, sync_in, prev_q);
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch
  import nmi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= latch_next(q, set, clr);
  end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h0c,
  parameter logic [ADDR_W-1:0] PEND_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] EN_OFS   = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              latch_q,
  output trig_mode_e        mode_q,
  output logic              en_q,
  output logic              mode_wr,
  output logic              clr_evt,
  output logic [DATA_W-1:0] rd_data
);
  logic en_wr;
  logic unused_wr_hi;

  assign mode_wr = wr_en && (wr_addr == MODE_OFS);
  assign en_wr   = wr_en && (wr_addr == EN_OFS);
  assign clr_evt = wr_en && (wr_addr == PEND_OFS) && wr_data[0];
  assign unused_wr_hi = ^wr_data[DATA_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_LVL_LO;
      en_q   <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= trig_mode_e'(wr_data[MODE_W-1:0]);
      if (en_wr)   en_q   <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == MODE_OFS)      rd_data[MODE_W-1:0] = mode_q;
    else if (rd_addr == PEND_OFS) rd_data[0] = latch_q & en_q;
    else if (rd_addr == EN_OFS)   rd_data[0] = en_q;
  end
endmodule

// File: rtl/nmi_trigger_latch.sv
module nmi_trigger_latch
  import nmi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pad,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req
);
  // Named internal events, visible to the bound checker.
  logic       pad_sync;
  logic       set_evt;
  logic       clr_evt;
  logic       mode_wr;
  logic       en_q;
  trig_mode_e mode_q;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_pad), .q(pad_sync)
  );

  nmi_detect u_detect (
    .clk(clk), .rst_n(rst_n), .sync_in(pad_sync), .mode(mode_q), .hit(set_evt)
  );

  nmi_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set(set_evt), .clr(clr_evt), .q(irq_req)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .latch_q(irq_req), .mode_q(mode_q), .en_q(en_q),
    .mode_wr(mode_wr), .clr_evt(clr_evt), .rd_data(rd_data)
  );
endmodule

// File: rtl/nmi_trigger_latch_chk.sv
module nmi_trigger_latch_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PEND_OFS = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_q,
  input logic              mode_wr,
  input logic              set_evt,
  input logic              clr_evt,
  input logic              en_q,
  input logic              irq_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq_req);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !irq_req);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt) |=> $stable(irq_req));

  // Edge modes (R5 rising, R6 falling) fire for one cycle per transition.
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && set_evt && !mode_wr) |=> !set_evt);

  assert_pend_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == PEND_OFS && !en_q) |-> (rd_data == '0));
endmodule

bind nmi_trigger_latch nmi_trigger_latch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mode_wr(mode_wr), .set_evt(set_evt),
  .clr_evt(clr_evt), .en_q(en_q), .irq_req(irq_req), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_nmi_trigger_latch.sv
`timescale 1ns/1ps
module tb_nmi_trigger_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pad = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nmi_trigger_latch dut (
    .clk(clk), .rst_n(rst_n), .nmi_pad(nmi_pad), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R4";
      1: return "R6";
      2: return "R3";
      default: return "R5";
    endcase
  endfunction

  // Pick a mode, park the pad at its idle level, then clear anything picked up on the way.
  task automatic setup_mode(input int m);
    nmi_pad = ~m[1];
    wr(8'h0c, 32'(m));
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h1);
    repeat (3) @(negedge clk);
    check({31'b0, irq_req}, 32'h0, "R7 idle after clear");
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check({31'b0, irq_req}, 32'h0, "R1 irq in reset");
    rd(8'h0c, v); check(v, 32'h0, "R1 mode in reset");
    rd(8'h10, v); check(v, 32'h0, "R1 pending in reset");
    rd(8'h40, v); check(v, 32'h0, "R1 enable in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      logic act;
      act = m[1];
      setup_mode(m);
      rd(8'h0c, v); check(v, 32'(m), "R2 mode readback");
      nmi_pad = act;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check({31'b0, irq_req}, 32'h0, "R12 not before third edge");
      @(posedge clk); @(negedge clk);
      check({31'b0, irq_req}, 32'h1, mode_tag(m));
      wr(8'h10, 32'h1);
      if (m[0] == 1'b0) begin
        check({31'b0, irq_req}, 32'h1, mode_tag(m));
        nmi_pad = ~act;
        repeat (4) @(negedge clk);
        check({31'b0, irq_req}, 32'h1, "R7 held after source gone");
        wr(8'h10, 32'hFFFF_FFFE);
        check({31'b0, irq_req}, 32'h1, "R8 zero bit ignored");
        rd(8'h10, v); check(v, 32'h0, "R9 pending masked");
        wr(8'h40, 32'h1);
        rd(8'h40, v); check(v, 32'h1, "R9 enable readback");
        rd(8'h10, v); check(v, 32'h1, "R9 pending visible");
        wr(8'h40, 32'h0);
        wr(8'h10, 32'h1);
        check({31'b0, irq_req}, 32'h0, "R7 clear");
      end else begin
        check({31'b0, irq_req}, 32'h0, mode_tag(m));
        nmi_pad = ~act;
        repeat (4) @(negedge clk);
        check({31'b0, irq_req}, 32'h0, mode_tag(m));
      end
    end

    // Detection and clear on the same edge.
    setup_mode(3);
    nmi_pad = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(8'h10, 32'h1);
    check({31'b0, irq_req}, 32'h1, "R10 set beats clear");
    wr(8'h10, 32'h1);
    check({31'b0, irq_req}, 32'h0, "R7 clear after tie");

    // Unmapped offsets.
    wr(8'h20, 32'h2);
    wr(8'h44, 32'h1);
    rd(8'h0c, v); check(v, 32'h3, "R11 mode untouched");
    rd(8'h40, v); check(v, 32'h0, "R11 enable untouched");
    rd(8'h20, v); check(v, 32'h0, "R11 unmapped read");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule